// File: doc/BRIEF.md
# Signal Tap Capture Unit

This block watches the write traffic of a processing datapath and keeps a copy of the words written at chosen addresses. It has eight channels. Each channel holds a tap address that can be set to any point in the processing flow. When a datapath write hits that address, the channel keeps the 28-bit word, which is in 5.23 fixed-point form. At each sample boundary the value each channel has caught moves into a held copy. Readers therefore always see a complete and consistent set of values from the last finished sample.

Channels 0 to 5 are read by the host through a plain select/data read port. Channels 6 and 7 are not visible to the host. Instead they feed a stereo serial output in I2S framing: channel 6 is the left sample and channel 7 is the right sample. Each sample is cut to its upper 24 bits and sent MSB first. This lets an external converter or analyser monitor any two internal signals live.

The datapath bus is a snoop port: `bus_valid` marks a write, and the block never pushes back on it. The bus has no ready, and every beat is observed in the cycle it is presented. The serial side is paced by `ser_tick`, one pulse per bit period, which comes from the bit-clock logic outside the block. The block never stalls the tick and never waits for it, so it has no back-pressure on either side.

Top module: `sigtap_capture`

## Requirements
- R1: After reset every tap address and every captured and held value is zero, `rd_data` reads zero for every select, and `ser_lrclk` and `ser_sdata` are low.
- R2: A cycle with `cfg_we` high sets the tap address of channel `cfg_ch` to `cfg_addr` from the next cycle on. The old address of that channel no longer captures.
- R3: A cycle with `bus_valid` high and `bus_addr` equal to a channel's tap address stores `bus_data` in that channel. A write to any other address leaves the channel unchanged. The last matching write within a sample is the one kept.
- R4: Host-visible values change only on a `frame_end` cycle. A matching write in the same cycle as `frame_end` belongs to the sample that is closing and is visible right after it.
- R5: A channel with no matching write during a sample keeps its previous value across further sample boundaries.
- R6: `rd_data` shows, in the same cycle, the held value of channel `rd_sel` for selects 0 to 5. Selects 6 and 7 read as zero.
- R7: The serializer counts `ser_tick` pulses through a 64-position frame. `ser_lrclk` is low for positions 0 to 31 (left) and high for positions 32 to 63 (right). Outputs change only after a tick.
- R8: At slot position s (position modulo 32) from 1 to 24, `ser_sdata` carries bit 24-s of the upper 24 bits of that side's word, which is bit 28-s of the 28-bit word. All other slot positions send zero.
- R9: The stereo pair is loaded from the held values of channels 6 and 7 on the tick that wraps position 63 to 0. A change in those held values during a frame does not affect the frame in progress.
- R10: Channels programmed to the same tap address all capture the same matching write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Tap address write strobe |
| cfg_ch | input | 3 | Channel whose tap address is written |
| cfg_addr | input | 10 | New tap address |
| bus_valid | input | 1 | Datapath write strobe (snoop, no ready) |
| bus_addr | input | 10 | Datapath write address |
| bus_data | input | 28 | Datapath write data, 5.23 format |
| frame_end | input | 1 | Sample boundary pulse |
| rd_sel | input | 3 | Host read channel select |
| rd_data | output | 28 | Held value of the selected channel |
| ser_tick | input | 1 | One pulse per serial bit period |
| ser_lrclk | output | 1 | Left/right word select |
| ser_sdata | output | 1 | Serial sample data |

## Verification
The bench puts a capture in the same cycle as a sample boundary, where a design that latched only the older value would lose that word for a whole sample. It writes twice to one address within a sample to confirm that the later word wins. It reads before the boundary to catch a design that lets live captures leak through to the host. It moves a tap address to confirm that the old address stops capturing, and it points several channels at one address to confirm that all of them capture.

On the serial side it changes the left source in the middle of a frame. A serializer that reads the held values directly, instead of loading them at the frame wrap, would send a torn sample. It also checks bit placement one position after the word-select edge, where an off-by-one framing would shift every bit of the word.

// File: rtl/sigtap_pkg.sv
package sigtap_pkg;
  localparam int DEF_HOST_CH = 6;
  localparam int DEF_ADDR_W  = 10;
  localparam int DEF_DATA_W  = 28;
  localparam int DEF_OUT_W   = 24;
  localparam int DEF_SLOT_W  = 32;

  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;
endpackage

// File: rtl/sigtap_channel.sv
module sigtap_channel #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              frame_end,
  output logic [DATA_W-1:0] held
);
  logic [ADDR_W-1:0] tap_q;
  logic [DATA_W-1:0] live_q;
  logic              hit;

  assign hit = bus_valid && (bus_addr == tap_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q  <= '0;
      live_q <= '0;
      held   <= '0;
    end else begin
      if (cfg_we) tap_q <= cfg_addr;
      if (hit) live_q <= bus_data;
      // a write on the boundary cycle closes the sample it belongs to
      if (frame_end) held <= hit ? bus_data : live_q;
    end
  end
endmodule

// File: rtl/sigtap_i2s_tx.sv
module sigtap_i2s_tx
  import sigtap_pkg::*;
#(
  parameter int DATA_W = 28,
  parameter int OUT_W  = 24,
  parameter int SLOT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [DATA_W-1:0] left_in,
  input  logic [DATA_W-1:0] right_in,
  output logic              lrclk,
  output logic              sdata
);
  localparam int CNT_W  = $clog2(2 * SLOT_W);
  localparam int SLOT_B = CNT_W - 1;

  logic [CNT_W-1:0]  pos_q;
  logic [OUT_W-1:0]  word_l, word_r, word_cur, word_sh;
  logic [SLOT_B-1:0] slot;
  side_e             side;
  int unsigned       sp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      word_l <= '0;
      word_r <= '0;
    end else if (tick) begin
      pos_q <= pos_q + 1'b1;
      if (pos_q == {CNT_W{1'b1}}) begin
        word_l <= left_in[DATA_W-1 -: OUT_W];
        word_r <= right_in[DATA_W-1 -: OUT_W];
      end
    end
  end

  assign slot     = pos_q[SLOT_B-1:0];
  assign side     = side_e'(pos_q[CNT_W-1]);
  assign lrclk    = (side == SIDE_RIGHT);
  assign word_cur = (side == SIDE_RIGHT) ? word_r : word_l;

  always_comb begin
    sp      = 32'(slot);
    word_sh = '0;
    sdata   = 1'b0;
    if (sp >= 1 && sp <= OUT_W) begin
      word_sh = word_cur << (sp - 1);
      sdata   = word_sh[OUT_W-1];
    end
  end
endmodule

// File: rtl/sigtap_capture.sv
module sigtap_capture
  import sigtap_pkg::*;
#(
  parameter int N_HOST = DEF_HOST_CH,
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int DATA_W = DEF_DATA_W,
  parameter int OUT_W  = DEF_OUT_W,
  parameter int SLOT_W = DEF_SLOT_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [$clog2(N_HOST+2)-1:0]      cfg_ch,
  input  logic [ADDR_W-1:0]                cfg_addr,
  input  logic                             bus_valid,
  input  logic [ADDR_W-1:0]                bus_addr,
  input  logic [DATA_W-1:0]                bus_data,
  input  logic                             frame_end,
  input  logic [$clog2(N_HOST+2)-1:0]      rd_sel,
  output logic [DATA_W-1:0]                rd_data,
  input  logic                             ser_tick,
  output logic                             ser_lrclk,
  output logic                             ser_sdata
);
  localparam int N_CH  = N_HOST + 2;
  localparam int SEL_W = $clog2(N_CH);
  localparam int L_IDX = N_HOST;
  localparam int R_IDX = N_HOST + 1;

  logic [DATA_W-1:0] held [N_CH];

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    sigtap_channel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we && (cfg_ch == SEL_W'(i))),
      .cfg_addr  (cfg_addr),
      .bus_valid (bus_valid),
      .bus_addr  (bus_addr),
      .bus_data  (bus_data),
      .frame_end (frame_end),
      .held      (held[i])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_HOST; i++)
      if (rd_sel == SEL_W'(i)) rd_data = held[i];
  end

  sigtap_i2s_tx #(.DATA_W(DATA_W), .OUT_W(OUT_W), .SLOT_W(SLOT_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (ser_tick),
    .left_in  (held[L_IDX]),
    .right_in (held[R_IDX]),
    .lrclk    (ser_lrclk),
    .sdata    (ser_sdata)
  );
endmodule

// File: rtl/sigtap_capture_chk.sv
module sigtap_capture_chk #(
  parameter int N_HOST = 6,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 28,
  parameter int OUT_W  = 24,
  parameter int SLOT_W = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        frame_end,
  input logic [$clog2(N_HOST+2)-1:0] rd_sel,
  input logic [DATA_W-1:0]           rd_data,
  input logic                        ser_tick,
  input logic                        ser_lrclk,
  input logic                        ser_sdata
);
  localparam int CNT_W = $clog2(2 * SLOT_W);

  logic [CNT_W-1:0] ref_pos;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_pos <= '0;
    else if (ser_tick) ref_pos <= ref_pos + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (rd_data == '0 && !ser_sdata && !ser_lrclk)
        else $error("outputs not cleared in reset");
    end
  end

  property p_hold_between_frames;
    @(posedge clk) disable iff (!rst_n)
      !frame_end |=> (rd_sel != $past(rd_sel)) || $stable(rd_data);
  endproperty
  assert_host_view_stable_R4: assert property (p_hold_between_frames);

  property p_stream_sel_zero;
    @(posedge clk) disable iff (!rst_n)
      (int'(rd_sel) >= N_HOST) |-> (rd_data == '0);
  endproperty
  assert_stream_sel_zero_R6: assert property (p_stream_sel_zero);

  property p_lr_phase;
    @(posedge clk) disable iff (!rst_n)
      ser_lrclk == ref_pos[CNT_W-1];
  endproperty
  assert_lr_phase_R7: assert property (p_lr_phase);

  property p_idle_no_change;
    @(posedge clk) disable iff (!rst_n)
      !ser_tick |=> $stable(ser_sdata) && $stable(ser_lrclk);
  endproperty
  assert_idle_no_change_R7: assert property (p_idle_no_change);

  property p_pad_zero;
    @(posedge clk) disable iff (!rst_n)
      (ref_pos[CNT_W-2:0] == '0 || int'(ref_pos[CNT_W-2:0]) > OUT_W) |-> !ser_sdata;
  endproperty
  assert_pad_zero_R8: assert property (p_pad_zero);
endmodule

bind sigtap_capture sigtap_capture_chk #(
  .N_HOST(N_HOST), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OUT_W(OUT_W), .SLOT_W(SLOT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frame_end (frame_end),
  .rd_sel    (rd_sel),
  .rd_data   (rd_data),
  .ser_tick  (ser_tick),
  .ser_lrclk (ser_lrclk),
  .ser_sdata (ser_sdata)
);

// File: tb/sigtap_capture_tb.sv
module sigtap_capture_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_ch = '0;
  logic [9:0]  cfg_addr = '0;
  logic        bus_valid = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [27:0] bus_data = '0;
  logic        frame_end = 1'b0;
  logic [2:0]  rd_sel = '0;
  logic [27:0] rd_data;
  logic        ser_tick = 1'b0;
  logic        ser_lrclk, ser_sdata;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [27:0] dv [8];

  always #5 clk = ~clk;

  sigtap_capture u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_addr(cfg_addr),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
    .frame_end(frame_end), .rd_sel(rd_sel), .rd_data(rd_data),
    .ser_tick(ser_tick), .ser_lrclk(ser_lrclk), .ser_sdata(ser_sdata)
  );

  task automatic check(input string req, input logic [27:0] act, input logic [27:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic program_tap(input int ch, input int addr);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_addr = 10'(addr);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic bus_write(input int addr, input logic [27:0] d, input bit fe);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = 10'(addr); bus_data = d; frame_end = fe;
    @(negedge clk);
    bus_valid = 1'b0; frame_end = 1'b0;
  endtask

  task automatic sample_end();
    @(negedge clk);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
  endtask

  task automatic read_ch(input int sel, output logic [27:0] v);
    rd_sel = 3'(sel);
    #1;
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [27:0] v;
    for (int s = 0; s < 8; s++) begin
      read_ch(s, v);
      check($sformatf("R1 reset read sel %0d", s), v, 28'h0);
    end
    check("R1 reset serial", {26'h0, ser_lrclk, ser_sdata}, 28'h0);
  endtask

  task automatic t_shared_addr();
    logic [27:0] v;
    bus_write(0, 28'h5A5A5A5, 1'b0);
    sample_end();
    for (int s = 0; s < 6; s++) begin
      read_ch(s, v);
      check($sformatf("R10 shared tap ch %0d", s), v, 28'h5A5A5A5);
    end
  endtask

  task automatic t_program_capture();
    logic [27:0] v;
    for (int c = 0; c < 8; c++) begin
      dv[c] = 28'h1000001 * (c + 3) ^ 28'hC3A5F0E;
      program_tap(c, 100 + c);
    end
    for (int c = 0; c < 8; c++) bus_write(100 + c, dv[c], 1'b0);
    read_ch(0, v);
    check("R4 no leak before boundary", v, 28'h5A5A5A5);
    sample_end();
    for (int c = 0; c < 6; c++) begin
      read_ch(c, v);
      check($sformatf("R2 R3 capture ch %0d", c), v, dv[c]);
    end
  endtask

  task automatic t_nonmatch_and_last();
    logic [27:0] v;
    bus_write(300, 28'hFFFFFFF, 1'b0);
    bus_write(101, 28'h0123456, 1'b0);
    bus_write(101, 28'h7654321, 1'b0);
    sample_end();
    read_ch(0, v);
    check("R3 non-matching write ignored", v, dv[0]);
    read_ch(1, v);
    check("R3 last write wins", v, 28'h7654321);
  endtask

  task automatic t_same_cycle();
    logic [27:0] v;
    bus_write(102, 28'h0BEEF12, 1'b1);
    read_ch(2, v);
    check("R4 write on boundary cycle visible", v, 28'h0BEEF12);
  endtask

  task automatic t_persist();
    logic [27:0] v;
    sample_end();
    sample_end();
    read_ch(3, v);
    check("R5 value persists", v, dv[3]);
    read_ch(2, v);
    check("R5 value persists ch2", v, 28'h0BEEF12);
  endtask

  task automatic t_stream_sel();
    logic [27:0] v;
    read_ch(6, v);
    check("R6 sel 6 reads zero", v, 28'h0);
    read_ch(7, v);
    check("R6 sel 7 reads zero", v, 28'h0);
    read_ch(4, v);
    check("R6 sel 4 reads held", v, dv[4]);
  endtask

  task automatic t_retap();
    logic [27:0] v;
    program_tap(0, 200);
    bus_write(100, 28'h1111111, 1'b0);
    sample_end();
    read_ch(0, v);
    check("R2 old tap address dropped", v, dv[0]);
    bus_write(200, 28'h2222222, 1'b0);
    sample_end();
    read_ch(0, v);
    check("R2 new tap address captures", v, 28'h2222222);
  endtask

  task automatic t_serial();
    logic [27:0] l_new = 28'h9876543;
    int err_lr = 0, err1 = 0, err2 = 0;
    @(negedge clk);
    ser_tick = 1'b1;
    for (int k = 1; k <= 192; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k >= 64) begin
        int p = k % 64;
        int s = p % 32;
        logic [23:0] w;
        logic eb;
        if (k < 128) w = (p < 32) ? dv[6][27:4] : dv[7][27:4];
        else         w = (p < 32) ? l_new[27:4] : dv[7][27:4];
        eb = (s >= 1 && s <= 24) ? w[24 - s] : 1'b0;
        if (ser_lrclk !== (p >= 32)) err_lr++;
        if (ser_sdata !== eb) begin
          if (k < 128) err1++; else err2++;
        end
      end
      if (k == 74) begin
        bus_valid = 1'b1; bus_addr = 10'd106; bus_data = l_new; frame_end = 1'b1;
      end
      if (k == 75) begin
        bus_valid = 1'b0; frame_end = 1'b0;
      end
    end
    ser_tick = 1'b0;
    check("R7 word select phase errors", 28'(err_lr), 28'h0);
    check("R8 R9 frame with mid-frame update errors", 28'(err1), 28'h0);
    check("R9 next frame carries new sample errors", 28'(err2), 28'h0);
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_shared_addr();
    t_program_capture();
    t_nonmatch_and_last();
    t_same_cycle();
    t_persist();
    t_stream_sel();
    t_retap();
    t_serial();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule